// File: doc/BRIEF.md
# Length-Framed Tape Record Engine

This block moves records between a byte-wide tape image memory and a 16-bit host memory. Every record on the image is enclosed by a 32-bit little-endian byte length, once in front of the data and once behind it. Because the length is also stored at the end, records can be crossed backwards as well as forwards. A zero length on its own is a file mark. The engine keeps a byte position into the image and moves it as records are read, written or skipped.

A controller sets the function code, the byte count (a negative two's-complement number that counts up toward zero) and an 18-bit host byte address, then pulses `start`. The engine clears `done`, runs the function, and raises `done` again with the updated count, address, position and status flags. The final address is returned split: the two extended bits form one field and the low sixteen bits form the current-address field. Command checking and register decode belong to the surrounding controller. `img_len` gives the number of valid bytes in the image, and forward motion stops at that point.

Function codes: 1 read, 2 write, 3 write file mark, 4 space forward, 5 space reverse, 6 write with extended gap (same tape effect as write). Codes 0 and 7 do nothing on tape.

Top module: `tape_rec_engine`

## Requirements
- R1: A write (code 2 or 6) of N = 65536 − count bytes stores the length N (4 bytes, least significant first), then the N data bytes, then one zero pad byte if N is odd, then N again. The position advances by N rounded up to even plus 8.
- R2: A write file mark (code 3) stores four zero bytes at the position and advances the position by 4.
- R3: A read (code 1) of a record of length L with requested size Q = 65536 − count transfers min(L, Q) bytes and sets the length error when L > Q. The position still advances by L rounded up to even plus 8.
- R4: Each transferred byte goes to host word address[17:1]. An even byte address fills bits 7:0 and an odd one fills bits 15:8, and only that byte lane is enabled. The address grows by one per byte, wrapping at 18 bits, and the count grows by one per byte.
- R5: When the address is at or above MEM_BYTES before a byte, the nonexistent-memory flag is set and no further host access occurs. A read stops moving data. A write stores zeros for the remaining data bytes and does not advance the address or count.
- R6: A read whose length field is zero sets EOF, moves the position by 4 and transfers nothing. A read where fewer than 4 bytes remain before `img_len` sets EOT and leaves the position unchanged.
- R7: Space forward (code 4) adds one to the count per record and stops when the count reaches zero. It stops early with EOF, after stepping past a file mark (+4), or with EOT at the image end. The count is incremented even for the step that finds EOT.
- R8: Space reverse (code 5) reads the length just below the position. Started at position 0, it sets BOT and changes neither the position nor the count. It sets EOF and retreats 4 on a file mark. It sets BOT with position 0 when a record reaches or passes the image start.
- R9: On completion, `addr_hi` holds bits 17:16 and `addr_lo` holds bits 15:0 of the final byte address.
- R10: `start` is accepted only while `done` is high. It clears all flags and lowers `done`, and `done` rises again when the function ends. `error` is the OR of the length, nonexistent-memory, EOF and EOT flags. Codes 0 and 7 only latch the count and address.
- R11: After reset, `done` is 1, and the position, count, address and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the function on the inputs |
| func | input | 3 | Function code |
| bc_in | input | 16 | Two's-complement byte or record count |
| addr_in | input | 18 | Host byte address |
| img_len | input | TAPE_AW+1 | Valid bytes in the tape image |
| busy | output | 1 | Function in progress |
| done | output | 1 | Engine idle with results valid |
| error | output | 1 | OR of the error flags |
| err_len | output | 1 | Record longer than requested |
| err_nxm | output | 1 | Host address out of range |
| st_eof | output | 1 | File mark met |
| st_eot | output | 1 | Image end met |
| st_bot | output | 1 | Image start met |
| bc_out | output | 16 | Updated count |
| addr_hi | output | 2 | Final address bits 17:16 |
| addr_lo | output | 16 | Final address bits 15:0 |
| tape_pos | output | TAPE_AW | Current image byte position |
| tp_addr | output | TAPE_AW | Tape memory byte address |
| tp_we | output | 1 | Tape memory write enable |
| tp_wdata | output | 8 | Tape memory write byte |
| tp_rdata | input | 8 | Tape memory read byte, one cycle after address |
| hm_addr | output | 17 | Host word address |
| hm_we | output | 1 | Host write enable |
| hm_be | output | 2 | Host byte lane enables |
| hm_wdata | output | 16 | Host write word |
| hm_rdata | input | 16 | Host read word, one cycle after address |

## Verification
The assertions assume that both memories return read data exactly one cycle after the address and that `img_len` does not change while a function runs. They also assume that record lengths on the image lie within the image and leave the position inside the tape address range. The stimulus meets these assumptions. It changes `img_len` only between functions, and it builds the image only through the engine's own writes, so every length field the engine later reads was produced by the engine. Transfer sizes and positions are kept small enough that no record wraps the tape address. The only out-of-range host addresses used are ones placed just below MEM_BYTES, so that the nonexistent-memory path is reached partway through a record.

// File: rtl/tre_pkg.sv
package tre_pkg;

   typedef enum logic [2:0] {
      FN_NOP_LO = 3'd0,
      FN_READ   = 3'd1,
      FN_WRITE  = 3'd2,
      FN_MARK   = 3'd3,
      FN_SPFWD  = 3'd4,
      FN_SPREV  = 3'd5,
      FN_WRGAP  = 3'd6,
      FN_NOP_HI = 3'd7
   } tre_fn_e;

   typedef enum logic [3:0] {
      S_IDLE,
      S_CHKF,
      S_CHKR,
      S_LGET,
      S_LEVAL,
      S_RXF,
      S_RXW,
      S_LPUT,
      S_WXF,
      S_WXP,
      S_PAD,
      S_FIN
   } tre_st_e;

   localparam int LEN_BYTES = 4;

endpackage

// File: rtl/tre_span.sv
// Record geometry: step over a record and clipped transfer size.
module tre_span
   import tre_pkg::*;
#(
   parameter int LW = 32,
   parameter int RW = 17
)(
   input  logic [LW-1:0] rec_len,
   input  logic [RW-1:0] want,
   output logic [LW:0]   step,
   output logic [RW-1:0] take,
   output logic          too_long
);

   initial begin
      assert (LW > RW && LW >= 8) else $error("tre_span: LW must exceed RW");
   end

   logic [LW:0] even_len;

   always_comb begin
      even_len = {1'b0, rec_len} + {{LW{1'b0}}, rec_len[0]};
      step     = even_len + (LW+1)'(2 * LEN_BYTES);
      too_long = rec_len > LW'(want);
      take     = too_long ? want : rec_len[RW-1:0];
   end

endmodule

// File: rtl/tre_len_reg.sv
// Little-endian length word, filled or emptied one byte lane at a time.
module tre_len_reg #(
   parameter int NB = 4,
   localparam int IW = (NB > 1) ? $clog2(NB) : 1
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [8*NB-1:0] load_val,
   input  logic          cap,
   input  logic [IW-1:0] idx,
   input  logic [7:0]    din,
   output logic [8*NB-1:0] word,
   output logic [7:0]    dout
);

   for (genvar g = 0; g < NB; g++) begin : g_lane
      logic [7:0] lane_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                         lane_q <= '0;
         else if (load)                      lane_q <= load_val[8*g +: 8];
         else if (cap && idx == IW'(g))      lane_q <= din;
      end
      assign word[8*g +: 8] = lane_q;
   end

   assign dout = word[8*idx +: 8];

endmodule

// File: rtl/tre_lane.sv
// Host byte lane steering between a byte address and 16-bit words.
module tre_lane #(
   parameter int AW       = 18,
   parameter bit ODD_HIGH = 1'b1
)(
   input  logic [AW-1:0] byte_addr,
   input  logic [7:0]    wbyte,
   input  logic [15:0]   rword,
   output logic [AW-2:0] word_addr,
   output logic [1:0]    be,
   output logic [15:0]   wword,
   output logic [7:0]    rbyte
);

   logic hi_sel;

   assign word_addr = byte_addr[AW-1:1];
   assign wword     = {wbyte, wbyte};

   if (ODD_HIGH) begin : g_odd_hi
      assign hi_sel = byte_addr[0];
   end else begin : g_odd_lo
      assign hi_sel = ~byte_addr[0];
   end

   assign be    = hi_sel ? 2'b10 : 2'b01;
   assign rbyte = hi_sel ? rword[15:8] : rword[7:0];

endmodule

// File: rtl/tape_rec_engine.sv
module tape_rec_engine
   import tre_pkg::*;
#(
   parameter int TAPE_AW   = 10,
   parameter int MEM_BYTES = 4096,
   parameter int ADDR_W    = 18,
   parameter int BC_W      = 16,
   parameter bit ODD_HIGH  = 1'b1
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [2:0]           func,
   input  logic [BC_W-1:0]      bc_in,
   input  logic [ADDR_W-1:0]    addr_in,
   input  logic [TAPE_AW:0]     img_len,
   output logic                 busy,
   output logic                 done,
   output logic                 error,
   output logic                 err_len,
   output logic                 err_nxm,
   output logic                 st_eof,
   output logic                 st_eot,
   output logic                 st_bot,
   output logic [BC_W-1:0]      bc_out,
   output logic [ADDR_W-17:0]   addr_hi,
   output logic [15:0]          addr_lo,
   output logic [TAPE_AW-1:0]   tape_pos,
   output logic [TAPE_AW-1:0]   tp_addr,
   output logic                 tp_we,
   output logic [7:0]           tp_wdata,
   input  logic [7:0]           tp_rdata,
   output logic [ADDR_W-2:0]    hm_addr,
   output logic                 hm_we,
   output logic [1:0]           hm_be,
   output logic [15:0]          hm_wdata,
   input  logic [15:0]          hm_rdata
);

   localparam int REQ_W = BC_W + 1;
   localparam int LEN_W = 8 * LEN_BYTES;
   localparam int CMP_W = LEN_W + 1;
   localparam int LI_W  = $clog2(LEN_BYTES);
   localparam int LC_W  = LI_W + 1;

   initial begin
      assert (ADDR_W == 18 && BC_W == 16)
         else $error("tape_rec_engine: address must be 18 bits, count 16 bits");
      assert (MEM_BYTES >= 2 && MEM_BYTES <= (1 << ADDR_W))
         else $error("tape_rec_engine: MEM_BYTES out of range");
      assert (TAPE_AW >= 4 && TAPE_AW <= 24)
         else $error("tape_rec_engine: TAPE_AW out of range");
   end

   tre_st_e               st;
   tre_fn_e               fn_q;
   logic [BC_W-1:0]       bc_q;
   logic [ADDR_W-1:0]     addr_q;
   logic [TAPE_AW-1:0]    pos_q, tcur, step_q;
   logic [REQ_W-1:0]      idx_q, take_q;
   logic [LC_W-1:0]       lctr;
   logic                  phase_q;
   logic                  f_len, f_nxm, f_eof, f_eot, f_bot, done_q;

   // ---- derived terms ----
   logic [REQ_W-1:0]      req_in, req_q;
   logic                  is_wr_in;
   tre_fn_e               fn_in;

   assign fn_in    = tre_fn_e'(func);
   assign is_wr_in = (fn_in == FN_WRITE) || (fn_in == FN_WRGAP);
   assign req_in   = {1'b1, {BC_W{1'b0}}} - {1'b0, bc_in};
   assign req_q    = {1'b1, {BC_W{1'b0}}} - {1'b0, bc_q};

   logic [CMP_W-1:0] pos_w, step_w;
   logic             at_eot, pos_lt4, mem_out, len_zero;

   // ---- length word ----
   logic              len_load, len_cap;
   logic [LI_W-1:0]   len_idx;
   logic [LEN_W-1:0]  len_val, len_word;
   logic [7:0]        len_byte;

   assign len_load = (st == S_IDLE) && start;
   assign len_val  = is_wr_in ? LEN_W'(req_in) : '0;
   assign len_cap  = (st == S_LGET) && (lctr != '0);
   assign len_idx  = (st == S_LGET) ? LI_W'(lctr - LC_W'(1)) : LI_W'(lctr);

   tre_len_reg #(.NB(LEN_BYTES)) u_len (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (len_load),
      .load_val (len_val),
      .cap      (len_cap),
      .idx      (len_idx),
      .din      (tp_rdata),
      .word     (len_word),
      .dout     (len_byte)
   );

   // ---- record geometry ----
   logic [LEN_W:0]    step_c;
   logic [REQ_W-1:0]  take_c;
   logic              long_c;

   tre_span #(.LW(LEN_W), .RW(REQ_W)) u_span (
      .rec_len  (len_word),
      .want     (req_q),
      .step     (step_c),
      .take     (take_c),
      .too_long (long_c)
   );

   // ---- host lane steering ----
   logic [7:0] lane_rbyte;

   tre_lane #(.AW(ADDR_W), .ODD_HIGH(ODD_HIGH)) u_lane (
      .byte_addr (addr_q),
      .wbyte     (tp_rdata),
      .rword     (hm_rdata),
      .word_addr (hm_addr),
      .be        (hm_be),
      .wword     (hm_wdata),
      .rbyte     (lane_rbyte)
   );

   always_comb begin
      pos_w    = CMP_W'(pos_q);
      step_w   = CMP_W'(step_c);
      at_eot   = (pos_w + CMP_W'(LEN_BYTES)) > CMP_W'(img_len);
      pos_lt4  = pos_w < CMP_W'(LEN_BYTES);
      mem_out  = CMP_W'(addr_q) >= CMP_W'(MEM_BYTES);
      len_zero = (len_word == '0);
   end

   // ---- memory port drive ----
   assign tp_addr = tcur;
   assign tp_we   = (st == S_LPUT) || (st == S_WXP) || (st == S_PAD);
   assign hm_we   = (st == S_RXW);

   always_comb begin
      case (st)
         S_LPUT:  tp_wdata = len_byte;
         S_WXP:   tp_wdata = f_nxm ? 8'h00 : lane_rbyte;
         default: tp_wdata = 8'h00;
      endcase
   end

   // ---- sequencer ----
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         fn_q    <= FN_NOP_LO;
         bc_q    <= '0;
         addr_q  <= '0;
         pos_q   <= '0;
         tcur    <= '0;
         step_q  <= '0;
         idx_q   <= '0;
         take_q  <= '0;
         lctr    <= '0;
         phase_q <= 1'b0;
         f_len   <= 1'b0;
         f_nxm   <= 1'b0;
         f_eof   <= 1'b0;
         f_eot   <= 1'b0;
         f_bot   <= 1'b0;
         done_q  <= 1'b1;
      end else begin
         case (st)
            S_IDLE: begin
               if (start) begin
                  fn_q    <= fn_in;
                  bc_q    <= bc_in;
                  addr_q  <= addr_in;
                  f_len   <= 1'b0;
                  f_nxm   <= 1'b0;
                  f_eof   <= 1'b0;
                  f_eot   <= 1'b0;
                  f_bot   <= 1'b0;
                  done_q  <= 1'b0;
                  lctr    <= '0;
                  idx_q   <= '0;
                  phase_q <= 1'b0;
                  take_q  <= req_in;
                  tcur    <= pos_q;
                  case (fn_in)
                     FN_READ, FN_SPFWD:          st <= S_CHKF;
                     FN_SPREV: begin
                        if (pos_q == '0) begin
                           f_bot <= 1'b1;
                           st    <= S_FIN;
                        end else begin
                           st    <= S_CHKR;
                        end
                     end
                     FN_WRITE, FN_WRGAP, FN_MARK: st <= S_LPUT;
                     default:                     st <= S_FIN;
                  endcase
               end
            end

            S_CHKF: begin
               if (fn_q == FN_SPFWD) bc_q <= bc_q + BC_W'(1);
               if (at_eot) begin
                  f_eot <= 1'b1;
                  st    <= S_FIN;
               end else begin
                  tcur <= pos_q;
                  lctr <= '0;
                  st   <= S_LGET;
               end
            end

            S_CHKR: begin
               bc_q <= bc_q + BC_W'(1);
               if (pos_lt4) begin
                  f_bot <= 1'b1;
                  pos_q <= '0;
                  st    <= S_FIN;
               end else begin
                  tcur <= pos_q - TAPE_AW'(LEN_BYTES);
                  lctr <= '0;
                  st   <= S_LGET;
               end
            end

            S_LGET: begin
               if (lctr == LC_W'(LEN_BYTES)) begin
                  st <= S_LEVAL;
               end else begin
                  tcur <= tcur + TAPE_AW'(1);
                  lctr <= lctr + LC_W'(1);
               end
            end

            S_LEVAL: begin
               case (fn_q)
                  FN_READ: begin
                     if (len_zero) begin
                        f_eof <= 1'b1;
                        pos_q <= pos_q + TAPE_AW'(LEN_BYTES);
                        st    <= S_FIN;
                     end else begin
                        f_len  <= long_c;
                        take_q <= take_c;
                        step_q <= step_c[TAPE_AW-1:0];
                        idx_q  <= '0;
                        tcur   <= pos_q + TAPE_AW'(LEN_BYTES);
                        st     <= S_RXF;
                     end
                  end
                  FN_SPFWD: begin
                     if (len_zero) begin
                        f_eof <= 1'b1;
                        pos_q <= pos_q + TAPE_AW'(LEN_BYTES);
                        st    <= S_FIN;
                     end else begin
                        pos_q <= pos_q + step_c[TAPE_AW-1:0];
                        st    <= (bc_q == '0) ? S_FIN : S_CHKF;
                     end
                  end
                  default: begin
                     if (len_zero) begin
                        f_eof <= 1'b1;
                        pos_q <= pos_q - TAPE_AW'(LEN_BYTES);
                        st    <= S_FIN;
                     end else if (step_w >= pos_w) begin
                        f_bot <= 1'b1;
                        pos_q <= '0;
                        st    <= S_FIN;
                     end else begin
                        pos_q <= pos_q - step_c[TAPE_AW-1:0];
                        st    <= (bc_q == '0) ? S_FIN : S_CHKR;
                     end
                  end
               endcase
            end

            S_RXF: begin
               if (idx_q == take_q) begin
                  pos_q <= pos_q + step_q;
                  st    <= S_FIN;
               end else if (mem_out) begin
                  f_nxm <= 1'b1;
                  pos_q <= pos_q + step_q;
                  st    <= S_FIN;
               end else begin
                  st <= S_RXW;
               end
            end

            S_RXW: begin
               addr_q <= addr_q + ADDR_W'(1);
               bc_q   <= bc_q + BC_W'(1);
               tcur   <= tcur + TAPE_AW'(1);
               idx_q  <= idx_q + REQ_W'(1);
               st     <= S_RXF;
            end

            S_LPUT: begin
               tcur <= tcur + TAPE_AW'(1);
               if (lctr == LC_W'(LEN_BYTES - 1)) begin
                  lctr <= '0;
                  if (fn_q == FN_MARK) begin
                     pos_q <= pos_q + TAPE_AW'(LEN_BYTES);
                     st    <= S_FIN;
                  end else if (phase_q) begin
                     pos_q <= pos_q + step_c[TAPE_AW-1:0];
                     st    <= S_FIN;
                  end else begin
                     idx_q <= '0;
                     st    <= S_WXF;
                  end
               end else begin
                  lctr <= lctr + LC_W'(1);
               end
            end

            S_WXF: begin
               if (idx_q == take_q) begin
                  if (take_q[0]) begin
                     st <= S_PAD;
                  end else begin
                     phase_q <= 1'b1;
                     lctr    <= '0;
                     st      <= S_LPUT;
                  end
               end else begin
                  if (mem_out) f_nxm <= 1'b1;
                  st <= S_WXP;
               end
            end

            S_WXP: begin
               tcur  <= tcur + TAPE_AW'(1);
               idx_q <= idx_q + REQ_W'(1);
               if (!f_nxm) begin
                  addr_q <= addr_q + ADDR_W'(1);
                  bc_q   <= bc_q + BC_W'(1);
               end
               st <= S_WXF;
            end

            S_PAD: begin
               tcur    <= tcur + TAPE_AW'(1);
               phase_q <= 1'b1;
               lctr    <= '0;
               st      <= S_LPUT;
            end

            S_FIN: begin
               done_q <= 1'b1;
               st     <= S_IDLE;
            end

            default: st <= S_IDLE;
         endcase
      end
   end

   // ---- outputs ----
   assign busy     = (st != S_IDLE);
   assign done     = done_q;
   assign err_len  = f_len;
   assign err_nxm  = f_nxm;
   assign st_eof   = f_eof;
   assign st_eot   = f_eot;
   assign st_bot   = f_bot;
   assign error    = f_len | f_nxm | f_eof | f_eot;
   assign bc_out   = bc_q;
   assign addr_hi  = addr_q[ADDR_W-1:16];
   assign addr_lo  = addr_q[15:0];
   assign tape_pos = pos_q;

   // ---- assertions ----
   p_single_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
      hm_we |-> ($countones(hm_be) == 1));

   p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      hm_we |=> ({addr_hi, addr_lo} == $past({addr_hi, addr_lo}) + ADDR_W'(1)));

   p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      hm_we |=> (bc_out == $past(bc_out) + BC_W'(1)));

   p_nxm_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      err_nxm |-> !hm_we);

   p_ports_apart_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(hm_we && tp_we));

   p_start_drops_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (start && done) |=> !done);

   p_idle_pos_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> $stable(tape_pos));

   p_len_err_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_len) |-> (busy && !hm_we));

endmodule

// File: tb/tb_tape_rec_engine.sv
module tb_tape_rec_engine;

   localparam int TAW  = 10;
   localparam int TSZ  = 1 << TAW;
   localparam int MEMB = 4096;
   localparam int HW   = MEMB / 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  func = 3'd0;
   logic [15:0] bc_in = 16'd0;
   logic [17:0] addr_in = 18'd0;
   logic [TAW:0] img_len = '0;
   logic        busy, done, error, err_len, err_nxm, st_eof, st_eot, st_bot;
   logic [15:0] bc_out;
   logic [1:0]  addr_hi;
   logic [15:0] addr_lo;
   logic [TAW-1:0] tape_pos, tp_addr;
   logic        tp_we;
   logic [7:0]  tp_wdata, tp_rdata;
   logic [16:0] hm_addr;
   logic        hm_we;
   logic [1:0]  hm_be;
   logic [15:0] hm_wdata, hm_rdata;

   always #2 clk = ~clk;

   tape_rec_engine #(.TAPE_AW(TAW), .MEM_BYTES(MEMB)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .func(func), .bc_in(bc_in),
      .addr_in(addr_in), .img_len(img_len), .busy(busy), .done(done),
      .error(error), .err_len(err_len), .err_nxm(err_nxm), .st_eof(st_eof),
      .st_eot(st_eot), .st_bot(st_bot), .bc_out(bc_out), .addr_hi(addr_hi),
      .addr_lo(addr_lo), .tape_pos(tape_pos), .tp_addr(tp_addr), .tp_we(tp_we),
      .tp_wdata(tp_wdata), .tp_rdata(tp_rdata), .hm_addr(hm_addr), .hm_we(hm_we),
      .hm_be(hm_be), .hm_wdata(hm_wdata), .hm_rdata(hm_rdata)
   );

   // memories seen by the design
   logic [7:0]  tmem [0:TSZ-1];
   logic [15:0] hmem [0:HW-1];

   always @(posedge clk) begin
      tp_rdata <= tmem[tp_addr];
      if (tp_we) tmem[tp_addr] <= tp_wdata;
      hm_rdata <= hmem[hm_addr[10:0]];
      if (hm_we) begin
         if (hm_be[0]) hmem[hm_addr[10:0]][7:0]  <= hm_wdata[7:0];
         if (hm_be[1]) hmem[hm_addr[10:0]][15:8] <= hm_wdata[15:8];
      end
   end

   // reference model state
   logic [7:0]  mt [0:TSZ-1];
   logic [15:0] mh [0:HW-1];
   int e_pos, e_bc, e_addr, img;
   bit e_len, e_nxm, e_eof, e_eot, e_bot;

   int n_cmp = 0, n_bad = 0;
   bit mon_en = 1'b0;
   bit finished = 1'b0;

   task automatic chk(input string rq, input string what, input int act, input int exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   function automatic int rd32(input int p);
      int v = 0;
      for (int k = 0; k < 4; k++) v = v | (int'(mt[(p + k) % TSZ]) << (8 * k));
      return v;
   endfunction

   task automatic wr32(input int p, input int v);
      for (int k = 0; k < 4; k++) mt[(p + k) % TSZ] = 8'((v >> (8 * k)) & 255);
   endtask

   function automatic int stepof(input int l);
      return ((l + 1) & ~1) + 8;
   endfunction

   task automatic model(input int f, input int bcv, input int adr);
      int l, q, n, p, b;
      e_bc = bcv; e_addr = adr;
      e_len = 0; e_nxm = 0; e_eof = 0; e_eot = 0; e_bot = 0;
      case (f)
         1: begin
            if (e_pos + 4 > img) e_eot = 1;
            else begin
               l = rd32(e_pos);
               if (l == 0) begin e_eof = 1; e_pos += 4; end
               else begin
                  q = 65536 - e_bc;
                  if (l > q) e_len = 1;
                  n = (l < q) ? l : q;
                  for (int i = 0; i < n; i++) begin
                     if (e_addr >= MEMB) begin e_nxm = 1; break; end
                     b = mt[(e_pos + 4 + i) % TSZ];
                     if (e_addr[0]) mh[e_addr >> 1][15:8] = 8'(b);
                     else           mh[e_addr >> 1][7:0]  = 8'(b);
                     e_addr = (e_addr + 1) & 18'h3FFFF;
                     e_bc   = (e_bc + 1) & 16'hFFFF;
                  end
                  e_pos = (e_pos + stepof(l)) % TSZ;
               end
            end
         end
         2, 6: begin
            n = 65536 - e_bc;
            wr32(e_pos, n);
            p = e_pos + 4;
            for (int i = 0; i < n; i++) begin
               if (e_nxm || e_addr >= MEMB) begin e_nxm = 1; b = 0; end
               else begin
                  b = e_addr[0] ? int'(mh[e_addr >> 1][15:8]) : int'(mh[e_addr >> 1][7:0]);
                  e_addr = (e_addr + 1) & 18'h3FFFF;
                  e_bc   = (e_bc + 1) & 16'hFFFF;
               end
               mt[p % TSZ] = 8'(b); p++;
            end
            if (n % 2 == 1) begin mt[p % TSZ] = 8'h00; p++; end
            wr32(p, n);
            e_pos = (e_pos + stepof(n)) % TSZ;
         end
         3: begin wr32(e_pos, 0); e_pos = (e_pos + 4) % TSZ; end
         4: begin
            forever begin
               e_bc = (e_bc + 1) & 16'hFFFF;
               if (e_pos + 4 > img) begin e_eot = 1; break; end
               l = rd32(e_pos);
               if (l == 0) begin e_eof = 1; e_pos += 4; break; end
               e_pos = (e_pos + stepof(l)) % TSZ;
               if (e_bc == 0) break;
            end
         end
         5: begin
            if (e_pos == 0) e_bot = 1;
            else forever begin
               e_bc = (e_bc + 1) & 16'hFFFF;
               if (e_pos < 4) begin e_bot = 1; e_pos = 0; break; end
               l = rd32(e_pos - 4);
               if (l == 0) begin e_eof = 1; e_pos -= 4; break; end
               if (stepof(l) >= e_pos) begin e_bot = 1; e_pos = 0; break; end
               e_pos -= stepof(l);
               if (e_bc == 0) break;
            end
         end
         default: ;
      endcase
   endtask

   task automatic check_outs(input string rq);
      chk(rq, "bc_out",  int'(bc_out), e_bc);
      chk("R9", "addr_hi", int'(addr_hi), (e_addr >> 16) & 3);
      chk("R9", "addr_lo", int'(addr_lo), e_addr & 16'hFFFF);
      chk(rq, "tape_pos", int'(tape_pos), e_pos);
      chk(rq, "err_len", int'(err_len), int'(e_len));
      chk(rq, "err_nxm", int'(err_nxm), int'(e_nxm));
      chk(rq, "st_eof", int'(st_eof), int'(e_eof));
      chk(rq, "st_eot", int'(st_eot), int'(e_eot));
      chk(rq, "st_bot", int'(st_bot), int'(e_bot));
      chk("R10", "error", int'(error), int'(e_len | e_nxm | e_eof | e_eot));
   endtask

   task automatic check_mems(input string rq);
      int bad_t = 0, bad_h = 0;
      for (int i = 0; i < TSZ; i++) if (tmem[i] !== mt[i]) bad_t++;
      for (int i = 0; i < HW; i++) if (hmem[i] !== mh[i]) bad_h++;
      chk(rq, "tape bytes differing", bad_t, 0);
      chk(rq, "host words differing", bad_h, 0);
   endtask

   task automatic run(input int f, input int bcv, input int adr, input bit poke, input string rq);
      int waitc = 0;
      mon_en = 0;
      model(f, bcv, adr);
      @(negedge clk);
      func = 3'(f); bc_in = 16'(bcv); addr_in = 18'(adr); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R10", "done low after start", int'(done), 0);
      if (poke) begin
         @(negedge clk);
         func = 3'd3; bc_in = 16'h1111; addr_in = 18'h2222; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (!done) begin
         @(negedge clk);
         waitc++;
         if (waitc > 5000) begin
            chk("R10", "watchdog: done never rose", 0, 1);
            break;
         end
      end
      check_outs(rq);
      check_mems(rq);
      mon_en = 1;
   endtask

   task automatic do_reset();
      mon_en = 0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      e_pos = 0; e_bc = 0; e_addr = 0;
      e_len = 0; e_nxm = 0; e_eof = 0; e_eot = 0; e_bot = 0;
      @(negedge clk);
      chk("R11", "done after reset", int'(done), 1);
      chk("R11", "busy after reset", int'(busy), 0);
      check_outs("R11");
      mon_en = 1;
   endtask

   // every idle clock: outputs must match the model's last result
   always @(negedge clk) begin
      if (mon_en && rst_n && done && !start && !finished) begin
         chk("R10", "idle bc_out", int'(bc_out), e_bc);
         chk("R8", "idle tape_pos", int'(tape_pos), e_pos);
      end
   end

   task automatic finish_up();
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(4 * 200000);
      chk("R10", "global watchdog expired", 0, 1);
      finish_up();
   end

   initial begin
      for (int i = 0; i < TSZ; i++) begin tmem[i] = 8'hEE; mt[i] = 8'hEE; end
      for (int i = 0; i < HW; i++) begin
         hmem[i] = 16'((i * 16'h9E37 + 16'h1234) & 16'hFFFF);
         mh[i]   = hmem[i];
      end
      img = 0; img_len = '0;
      do_reset();

      // build image: A(5, odd, busy poke), B(6, odd address), mark, C(4, NXM mid-record)
      run(2, 16'hFFFB, 18'h00010, 1'b1, "R1");
      run(2, 16'hFFFA, 18'h00021, 1'b0, "R4");
      run(3, 16'h0000, 18'h00000, 1'b0, "R2");
      run(6, 16'hFFFC, MEMB - 2,  1'b0, "R5");
      img = e_pos; img_len = (TAW+1)'(img);

      // reverse across C, then onto the mark, then back to the start
      run(5, 16'hFFFF, 18'h0, 1'b0, "R8");
      run(5, 16'hFFFF, 18'h0, 1'b0, "R8");
      run(5, 16'h0000, 18'h0, 1'b0, "R8");

      // reads: clipped, odd address, mark, full, end of image
      run(1, 16'hFFFD, 18'h00100, 1'b0, "R3");
      run(1, 16'hFFF6, 18'h00201, 1'b0, "R4");
      run(1, 16'hFFF0, 18'h00300, 1'b0, "R6");
      run(1, 16'hFFF8, 18'h00300, 1'b0, "R3");
      run(1, 16'hFFF8, 18'h00300, 1'b0, "R6");

      // reverse stops on the mark from the end
      run(5, 16'h0000, 18'h0, 1'b0, "R8");

      // reset, then reverse at position zero
      do_reset();
      run(5, 16'hFFF0, 18'h00055, 1'b0, "R8");

      // forward spacing: stops on mark, stops on count, stops at end
      run(4, 16'h0000, 18'h0, 1'b0, "R7");
      run(4, 16'hFFFF, 18'h0, 1'b0, "R7");
      run(4, 16'hFFF0, 18'h0, 1'b0, "R7");

      // unused code only latches count and address
      run(0, 16'h1234, 18'h2ABCD, 1'b0, "R10");
      run(7, 16'h4321, 18'h10000, 1'b0, "R9");

      // read running off the top of host memory
      run(5, 16'hFFFF, 18'h0, 1'b0, "R8");
      run(1, 16'hFFFC, MEMB - 1, 1'b0, "R5");

      repeat (4) @(negedge clk);
      finish_up();
   end

endmodule